// File: doc/BRIEF.md
# Shared-Line Interrupt Vector Arbiter

Several low-priority peripheral interrupt sources share a single interrupt input of the processor core. This block gathers their requests and keeps a sticky pending bit for each one. It raises the shared core line for as long as at least one enabled source is pending. Seven sources are supported: a serial peripheral port, a serial receiver, a serial transmitter, an analog-to-digital converter and three external pins.

When the core acknowledges the shared line, the block picks the enabled pending source that has the best fixed priority. It loads that source's vector offset into the system vector register and clears the source's pending bit. The interrupt service code reads the register to dispatch. On the chip this register is mapped at address 0x701E. If the core acknowledges while no enabled source is pending, the register receives a phantom offset of zero. Every source can be masked.

Top module: `pirq_vector_arb`

## Requirements
- R1: While reset is high, and in the first cycle after it, `irq_out` is 0 and `vec_out` is 0x0000.
- R2: A one-cycle high pulse on `src_req[i]` sets the pending bit of source i. From the next cycle on, `irq_out` is 1 if `src_en[i]` is 1.
- R3: A pending source whose `src_en` bit is 0 does not drive `irq_out` and does not take part in arbitration. It stays pending, so setting its enable bit later raises `irq_out` and lets it win.
- R4: Arbitration grants the lowest-numbered enabled pending source. Bit order, from best to worst, is: 0 serial port, 1 serial receive, 2 serial transmit, 3 converter, 4 external 1, 5 external 2, 6 external 3.
- R5: The offset loaded for each winner is bit0 0x0005, bit1 0x0006, bit2 0x0007, bit3 0x0004, bit4 0x0001, bit5 0x0011, bit6 0x001F. It appears on `vec_out` in the cycle after the `ack` cycle.
- R6: On an acknowledge, only the winning source's pending bit is cleared. The bits of all other sources are kept.
- R7: After an acknowledge, `irq_out` stays 1 while any other enabled source is still pending.
- R8: An acknowledge with no enabled source pending loads 0x0000 into `vec_out`.
- R9: A request pulse in the same cycle as `ack` takes part in that arbitration.
- R10: `vec_out` keeps its value in every cycle without `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 7 | Request pulses, one bit per source, in priority order |
| src_en | input | 7 | Per-source enable mask |
| ack | input | 1 | Core acknowledge of the shared line, one cycle |
| irq_out | output | 1 | Shared core interrupt line |
| vec_out | output | 16 | System vector register contents |

## Verification
A corrupted pending bit shows up in one of two ways. Either `irq_out` is wrong in the very next cycle, or a later acknowledge returns the wrong offset or a phantom zero, one cycle after that acknowledge. A priority or offset fault shows on `vec_out` one cycle after the `ack` that exposes it. Draining all seven sources one by one walks every position of the order. Mixing masked sources and same-cycle requests into the acknowledges exposes faults in the candidate set.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NSRC = 7;
    localparam int VW   = 16;
    localparam int IW   = $clog2(NSRC);

    localparam logic [VW-1:0] PHANTOM_VEC = '0;

    typedef enum logic [IW-1:0] {
        SRC_SPORT  = 3'd0,
        SRC_SRX    = 3'd1,
        SRC_STX    = 3'd2,
        SRC_CONV   = 3'd3,
        SRC_EXT1   = 3'd4,
        SRC_EXT2   = 3'd5,
        SRC_EXT3   = 3'd6
    } src_e;

    typedef struct packed {
        logic          hit;
        logic [IW-1:0] idx;
    } pick_t;

    function automatic logic [VW-1:0] src_offset(input logic [IW-1:0] idx);
        logic [VW-1:0] v;
        case (src_e'(idx))
            SRC_SPORT: v = 16'h0005;
            SRC_SRX:   v = 16'h0006;
            SRC_STX:   v = 16'h0007;
            SRC_CONV:  v = 16'h0004;
            SRC_EXT1:  v = 16'h0001;
            SRC_EXT2:  v = 16'h0011;
            SRC_EXT3:  v = 16'h001F;
            default:   v = PHANTOM_VEC;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pirq_pend_bank.sv
module pirq_pend_bank #(
    parameter int N = pirq_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         ack,
    input  logic [N-1:0] grant,
    output logic [N-1:0] pend_q
);

    logic [N-1:0] pend_d;

    always_comb begin
        pend_d = pend_q | req;
        if (ack) pend_d = pend_d & ~grant;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ack |=> ((pend_q & $past(grant)) == '0)); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2

    AST_LOSERS_KEPT: assert property (@(posedge clk) disable iff (rst)
        ack |=> ((pend_q & ($past(pend_q) & ~$past(grant))) == ($past(pend_q) & ~$past(grant)))); // R6

endmodule

// File: rtl/pirq_prio_pick.sv
module pirq_prio_pick
    import pirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cand,
    output logic [N-1:0] grant,
    output pick_t        pick
);

    always_comb begin
        pick  = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.hit = 1'b1;
                pick.idx = IW'(i);
                grant    = N'(1) << i;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R4

    AST_GRANT_IN_CAND: assert property (@(posedge clk) disable iff (rst)
        (grant & ~cand) == '0); // R3

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (((grant - N'(1)) & cand) == '0)); // R4

endmodule

// File: rtl/pirq_vec_reg.sv
module pirq_vec_reg
    import pirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ack,
    input  pick_t         pick,
    output logic [VW-1:0] vec_q
);

    always_ff @(posedge clk) begin
        if (rst)      vec_q <= PHANTOM_VEC;
        else if (ack) vec_q <= pick.hit ? src_offset(pick.idx) : PHANTOM_VEC;
    end

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ack |=> $stable(vec_q)); // R10

    AST_PHANTOM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ack && !pick.hit) |=> (vec_q == PHANTOM_VEC)); // R8

    AST_REAL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (ack && pick.hit) |=> (vec_q != PHANTOM_VEC)); // R5

endmodule

// File: rtl/pirq_vector_arb.sv
module pirq_vector_arb
    import pirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] src_en,
    input  logic            ack,
    output logic            irq_out,
    output logic [VW-1:0]   vec_out
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] cand;
    logic [NSRC-1:0] grant;
    pick_t           pick;

    assign cand    = (pend_q | src_req) & src_en;
    assign irq_out = |(pend_q & src_en);

    pirq_pend_bank #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .req    (src_req),
        .ack    (ack),
        .grant  (grant),
        .pend_q (pend_q)
    );

    pirq_prio_pick #(.N(NSRC)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .cand  (cand),
        .grant (grant),
        .pick  (pick)
    );

    pirq_vec_reg u_vec (
        .clk   (clk),
        .rst   (rst),
        .ack   (ack),
        .pick  (pick),
        .vec_q (vec_out)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && vec_out == PHANTOM_VEC)); // R1

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (src_en == '0) |-> !irq_out); // R3

endmodule

// File: tb/sim_pirq_vector_arb.sv
`timescale 1ns/1ps
module sim_pirq_vector_arb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  src_req = '0;
    logic [6:0]  src_en  = '0;
    logic        ack     = 1'b0;
    logic        irq_out;
    logic [15:0] vec_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        ack_d = 1'b0;

    always #2.5 clk = ~clk;

    pirq_vector_arb u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
        .ack(ack), .irq_out(irq_out), .vec_out(vec_out)
    );

    always @(posedge clk) ack_d <= ack;

    // monitor: pops the expected vector one cycle after each acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (ack_d && !rst && exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (vec_out !== e) begin
                    fails++;
                    $display("FAIL %s: vec_out=%h expected %h", t, vec_out, e);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [6:0] m);
        src_req = m;
        step();
        src_req = '0;
    endtask

    task automatic do_ack(input logic [15:0] e, input string t);
        ack = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        step();
        ack = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_out !== e) begin
            fails++;
            $display("FAIL %s: irq_out=%b expected %b", t, irq_out, e);
        end
    endtask

    task automatic chk_vec(input logic [15:0] e, input string t);
        checks++;
        if (vec_out !== e) begin
            fails++;
            $display("FAIL %s: vec_out=%h expected %h", t, vec_out, e);
        end
    endtask

    initial begin
        repeat (4) step();
        chk_irq(1'b0, "R1 in reset");
        rst = 1'b0;
        step();
        chk_irq(1'b0, "R1");
        chk_vec(16'h0000, "R1");

        // R8 phantom with nothing pending
        src_en = 7'h7F;
        do_ack(16'h0000, "R8 empty");

        // R2 single request, external 3
        pulse(7'b1000000);
        chk_irq(1'b1, "R2");
        do_ack(16'h001F, "R5 ext3");
        chk_irq(1'b0, "R6 drained");

        // R4/R5/R7 all sources at once, drained in order
        pulse(7'h7F);
        chk_irq(1'b1, "R2 all");
        do_ack(16'h0005, "R4 sport");  chk_irq(1'b1, "R7");
        do_ack(16'h0006, "R4 srx");    chk_irq(1'b1, "R7");
        do_ack(16'h0007, "R4 stx");    chk_irq(1'b1, "R7");
        do_ack(16'h0004, "R4 conv");   chk_irq(1'b1, "R7");
        do_ack(16'h0001, "R4 ext1");   chk_irq(1'b1, "R7");
        do_ack(16'h0011, "R4 ext2");   chk_irq(1'b1, "R7");
        do_ack(16'h001F, "R4 ext3");   chk_irq(1'b0, "R6 last");
        do_ack(16'h0000, "R8 after drain");

        // R3 masked source stays pending, silent, not arbitrated
        src_en = '0;
        pulse(7'b0000001);
        chk_irq(1'b0, "R3 masked");
        do_ack(16'h0000, "R3 masked ack");
        src_en = 7'b0000001;
        #1;
        chk_irq(1'b1, "R3 unmasked");
        step();
        do_ack(16'h0005, "R3 late win");

        // R3 partial mask skips the better source
        src_en = 7'b1111110;
        pulse(7'b0000101);
        do_ack(16'h0007, "R3 skip masked");
        chk_irq(1'b0, "R3 only masked left");
        src_en = 7'h7F;
        #1;
        chk_irq(1'b1, "R3 re-enabled");
        step();
        do_ack(16'h0005, "R6 kept");

        // R9 request arriving with acknowledge wins
        pulse(7'b0001000);
        src_req = 7'b0000010;
        do_ack(16'h0006, "R9 same cycle");
        src_req = '0;
        chk_irq(1'b1, "R7 conv left");
        do_ack(16'h0004, "R9 follow-up");

        // R10 vector holds without acknowledge
        pulse(7'b0010000);
        repeat (3) step();
        chk_vec(16'h0004, "R10 hold");
        do_ack(16'h0001, "R5 ext1");
        step();
        chk_vec(16'h0001, "R10 after");

        step();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule